// File: doc/BRIEF.md
# Consistency-Model Memory Retire Gate

This block keeps an age-ordered queue of in-flight memory operations and decides, every cycle, which of them may leave the memory unit. Each slot holds an operation kind (load, store or fence), a flag saying the access has completed, a limbo flag for a load that finished before some older store knew its address, an address-known flag for stores and, on fences, a flag that makes the fence hold back younger loads. A model select input picks one of three ordering disciplines: sequential, processor or release consistency.

The gate recomputes its decision from the queue contents alone, so an entry held back by limbo or by a fence becomes eligible on the first cycle after the holding condition is cleared. Removal and compaction of the survivors toward the head, together with the append of one new operation, complete in one clock edge. Completion, limbo and address-known flags are set or cleared by per-slot masks from the surrounding pipeline. The model select must only change while the queue is empty.

Top module: `mrg_retire_gate`

## Requirements
- R1: After reset the queue is empty: occupancy is 0, retire_mask is 0 and enq_ready is 1.
- R2: With model_sel = 0 (sequential), retire_mask is the longest run of slots starting at slot 0 (the oldest) whose entries are ready, where a load or store is ready when its completion flag is set and a fence is always ready; no load leaves past an older store that stays.
- R3: With model_sel = 1 (processor), a ready load leaves when every older load and fence leaves in the same cycle, even if older stores stay; a store or fence leaves only when every older entry leaves in the same cycle.
- R4: With model_sel = 2 (release), a completed store or completed non-limbo load leaves regardless of older incomplete entries, and no load or store leaves before its completion flag is set.
- R5: With model_sel = 2, a load whose limbo flag is set never leaves; it becomes eligible in the cycle after its limbo flag is cleared.
- R6: With model_sel = 2, a load younger than a fence whose hold-loads flag is set does not leave while that fence is in the queue; stores pass such a fence, and a fence without the flag holds no load.
- R7: Under every model a fence leaves only in a cycle in which every older entry leaves.
- R8: Under every model a load with its limbo flag set does not leave while any older store in the queue lacks its address-known flag.
- R9: At each edge the entries that stay move to the lowest slots in their original order, an accepted new entry goes into the first slot after them, and occupancy becomes old occupancy minus retired count plus accepted count.
- R10: enq_ready is 1 exactly when occupancy is below DEPTH; an enqueue request while enq_ready is 0 is dropped.
- R11: Bit i of done_set, limbo_set, limbo_clr and addr_ok_set acts on the entry in slot i at the coming edge, before compaction moves it; op encodings are load 0, store 1, fence 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_sel | input | 2 | Ordering model: 0 sequential, 1 processor, 2 release |
| enq_valid | input | 1 | Request to append one operation at the tail |
| enq_op | input | 2 | Kind of the appended operation: 0 load, 1 store, 2 fence |
| enq_blk_ld | input | 1 | Appended fence holds back younger loads |
| enq_ready | output | 1 | The queue has a free slot |
| done_set | input | DEPTH | Per-slot: mark the access completed |
| limbo_set | input | DEPTH | Per-slot: set the limbo flag |
| limbo_clr | input | DEPTH | Per-slot: clear the limbo flag |
| addr_ok_set | input | DEPTH | Per-slot: mark the store address as known |
| retire_mask | output | DEPTH | Slots leaving at the coming edge, bit 0 oldest |
| occupancy | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
The main function is driven with mixes that separate the three models: a completed load behind an incomplete store (held under sequential, released under processor), a completed store behind an incomplete load (released only under release), and fences with and without the hold-loads flag sitting between completed loads and stores. Limbo loads are tried with an older store whose address is unknown and then known, and under release with the limbo flag set and then cleared. Flag updates land on slots just before those slots are compacted, which tells whether updates act on the pre-shift position, and a request at full occupancy shows that a dropped enqueue leaves the count intact.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

   typedef enum logic [1:0] {
      MDL_SEQ  = 2'd0,
      MDL_PROC = 2'd1,
      MDL_REL  = 2'd2
   } model_e;

   typedef enum logic [1:0] {
      OP_LD = 2'd0,
      OP_ST = 2'd1,
      OP_FN = 2'd2
   } op_e;

   typedef struct packed {
      logic vld;
      op_e  op;
      logic done;
      logic limbo;
      logic resolved;
      logic blk_ld;
   } ment_t;

endpackage

// File: rtl/mrg_update.sv
module mrg_update
   import mrg_pkg::*;
#(
   parameter int unsigned DEPTH          = 8,
   parameter bit          LIMBO_SET_WINS = 1'b1
) (
   input  ment_t [DEPTH-1:0] cur,
   input  logic  [DEPTH-1:0] done_set,
   input  logic  [DEPTH-1:0] limbo_set,
   input  logic  [DEPTH-1:0] limbo_clr,
   input  logic  [DEPTH-1:0] addr_ok_set,
   output ment_t [DEPTH-1:0] upd
);

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic lim_nxt;

      if (LIMBO_SET_WINS) begin : g_set_first
         assign lim_nxt = limbo_set[gi] | (cur[gi].limbo & ~limbo_clr[gi]);
      end else begin : g_clr_first
         assign lim_nxt = ~limbo_clr[gi] & (cur[gi].limbo | limbo_set[gi]);
      end

      always_comb begin
         upd[gi]          = cur[gi];
         upd[gi].done     = cur[gi].done | done_set[gi];
         upd[gi].limbo    = lim_nxt;
         upd[gi].resolved = cur[gi].resolved | addr_ok_set[gi];
      end
   end

endmodule

// File: rtl/mrg_rules.sv
module mrg_rules
   import mrg_pkg::*;
#(
   parameter int unsigned DEPTH = 8
) (
   input  model_e            model,
   input  ment_t [DEPTH-1:0] q,
   output logic  [DEPTH-1:0] rm
);

   logic [DEPTH:0] all_gone;
   logic [DEPTH:0] nonst_gone;
   logic [DEPTH:0] st_unres;
   logic [DEPTH:0] fn_block;

   assign all_gone[0]   = 1'b1;
   assign nonst_gone[0] = 1'b1;
   assign st_unres[0]   = 1'b0;
   assign fn_block[0]   = 1'b0;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rule
      logic is_ld, is_st, is_fn;
      logic ready, lim_ok, go;

      assign is_ld  = q[gi].vld && (q[gi].op == OP_LD);
      assign is_st  = q[gi].vld && (q[gi].op == OP_ST);
      assign is_fn  = q[gi].vld && (q[gi].op == OP_FN);
      assign ready  = is_fn || ((is_ld || is_st) && q[gi].done);
      assign lim_ok = !(is_ld && q[gi].limbo && st_unres[gi]);

      always_comb begin
         go = 1'b0;
         unique case (model)
            MDL_SEQ:  go = ready && all_gone[gi];
            MDL_PROC: go = ready && (is_ld ? nonst_gone[gi] : all_gone[gi]);
            MDL_REL: begin
               if (is_ld)      go = ready && !q[gi].limbo && !fn_block[gi];
               else if (is_st) go = ready;
               else            go = ready && all_gone[gi];
            end
            default:  go = 1'b0;
         endcase
         go = go && lim_ok;
      end

      assign rm[gi]           = go;
      assign all_gone[gi+1]   = all_gone[gi] && (go || !q[gi].vld);
      assign nonst_gone[gi+1] = nonst_gone[gi] && (go || !q[gi].vld || is_st);
      assign st_unres[gi+1]   = st_unres[gi] || (is_st && !q[gi].resolved);
      assign fn_block[gi+1]   = fn_block[gi] || (is_fn && q[gi].blk_ld);
   end

endmodule

// File: rtl/mrg_compact.sv
module mrg_compact
   import mrg_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  ment_t [DEPTH-1:0] cur,
   input  logic  [DEPTH-1:0] rm,
   input  logic              enq_fire,
   input  ment_t             new_ent,
   output ment_t [DEPTH-1:0] nxt,
   output logic  [CW-1:0]    count
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] k;

   always_comb begin
      nxt = '0;
      k   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cur[i].vld && !rm[i]) begin
            nxt[k[IW-1:0]] = cur[i];
            k              = k + 1'b1;
         end
      end
      if (enq_fire && (k < FULL)) begin
         nxt[k[IW-1:0]] = new_ent;
         k              = k + 1'b1;
      end
      count = k;
   end

endmodule

// File: rtl/mrg_retire_gate.sv
module mrg_retire_gate
   import mrg_pkg::*;
#(
   parameter int unsigned DEPTH          = 8,
   parameter bit          LIMBO_SET_WINS = 1'b1,
   localparam int unsigned CW            = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       model_sel,
   input  logic             enq_valid,
   input  logic [1:0]       enq_op,
   input  logic             enq_blk_ld,
   output logic             enq_ready,
   input  logic [DEPTH-1:0] done_set,
   input  logic [DEPTH-1:0] limbo_set,
   input  logic [DEPTH-1:0] limbo_clr,
   input  logic [DEPTH-1:0] addr_ok_set,
   output logic [DEPTH-1:0] retire_mask,
   output logic [CW-1:0]    occupancy
);

   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("mrg_retire_gate: DEPTH must lie in 2..32");
   end

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   ment_t [DEPTH-1:0] q_r;
   ment_t [DEPTH-1:0] q_upd;
   ment_t [DEPTH-1:0] q_nxt;
   logic  [CW-1:0]    occ_r;
   logic  [CW-1:0]    occ_nxt;
   logic              enq_fire;
   ment_t             new_ent;
   model_e            model;

   assign model     = model_e'(model_sel);
   assign enq_ready = (occ_r < FULL);
   assign enq_fire  = enq_valid && enq_ready;

   always_comb begin
      new_ent          = '0;
      new_ent.vld      = 1'b1;
      new_ent.op       = op_e'(enq_op);
      new_ent.resolved = (enq_op != OP_ST);
      new_ent.blk_ld   = (enq_op == OP_FN) && enq_blk_ld;
   end

   mrg_rules #(.DEPTH(DEPTH)) rules_i (
      .model (model),
      .q     (q_r),
      .rm    (retire_mask)
   );

   mrg_update #(.DEPTH(DEPTH), .LIMBO_SET_WINS(LIMBO_SET_WINS)) update_i (
      .cur         (q_r),
      .done_set    (done_set),
      .limbo_set   (limbo_set),
      .limbo_clr   (limbo_clr),
      .addr_ok_set (addr_ok_set),
      .upd         (q_upd)
   );

   mrg_compact #(.DEPTH(DEPTH)) compact_i (
      .cur      (q_upd),
      .rm       (retire_mask),
      .enq_fire (enq_fire),
      .new_ent  (new_ent),
      .nxt      (q_nxt),
      .count    (occ_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         occ_r <= '0;
      end else begin
         q_r   <= q_nxt;
         occ_r <= occ_nxt;
      end
   end

   assign occupancy = occ_r;

endmodule

// File: rtl/mrg_retire_gate_chk.sv
module mrg_retire_gate_chk
   import mrg_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        model_sel,
   input logic [DEPTH-1:0]  rm,
   input logic [CW-1:0]     occ,
   input logic              enq_fire,
   input ment_t [DEPTH-1:0] q
);

   logic [DEPTH-1:0] older_unres;
   logic [DEPTH-1:0] older_blk;

   always_comb begin
      logic us, bf;
      us = 1'b0;
      bf = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         older_unres[i] = us;
         older_blk[i]   = bf;
         us = us | (q[i].vld && q[i].op == OP_ST && !q[i].resolved);
         bf = bf | (q[i].vld && q[i].op == OP_FN && q[i].blk_ld);
      end
   end

   // R1
   reset_empty_chk: assert property (@(posedge clk) !rst_n |=> (occ == '0));

   // R2
   sc_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (model_sel == 2'd0) |-> ((rm & (rm + 1'b1)) == '0));

   // R9
   rm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (({{DEPTH{1'b0}}, rm} >> occ) == '0));

   // R9
   occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (int'(occ) == int'($past(occ)) - $countones($past(rm)) + int'($past(enq_fire))));

   // R10
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CW'(DEPTH)) |-> !enq_fire);

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      localparam longint unsigned LOWI = (64'd1 << gi) - 64'd1;
      localparam logic [DEPTH-1:0] LOW = LOWI[DEPTH-1:0];

      // R7
      fence_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rm[gi] && q[gi].op == OP_FN) |-> ((rm & LOW) == LOW));

      // R3
      store_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (model_sel != 2'd2 && rm[gi] && q[gi].op == OP_ST) |-> ((rm & LOW) == LOW));

      // R4
      done_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rm[gi] && q[gi].op != OP_FN) |-> q[gi].done);

      // R5
      rc_limbo_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (model_sel == 2'd2 && q[gi].vld && q[gi].op == OP_LD && q[gi].limbo) |-> !rm[gi]);

      // R6
      rc_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (model_sel == 2'd2 && rm[gi] && q[gi].op == OP_LD) |-> !older_blk[gi]);

      // R8
      limbo_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rm[gi] && q[gi].op == OP_LD && q[gi].limbo) |-> !older_unres[gi]);
   end

endmodule

bind mrg_retire_gate mrg_retire_gate_chk #(.DEPTH(DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .model_sel (model_sel),
   .rm        (retire_mask),
   .occ       (occupancy),
   .enq_fire  (enq_fire),
   .q         (q_r)
);

// File: tb/mrg_retire_gate_tb_top.sv
module mrg_retire_gate_tb_top;

   localparam int unsigned D = 4;
   localparam logic [1:0] LD = 2'd0, ST = 2'd1, FN = 2'd2;

   typedef struct packed {
      logic [1:0] md;
      logic       en;
      logic [1:0] ty;
      logic       bl;
      logic [3:0] pf;
      logic [3:0] ls;
      logic [3:0] lc;
      logic [3:0] rs;
      logic [3:0] xrm;
      logic [2:0] xo;
      logic [3:0] rq;
   } vec_t;

   // md en ty bl pf ls lc rs | expected retire, occupancy | requirement
   localparam vec_t TBL [0:47] = '{
      // sequential: R2, R11
      '{2'd0,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd2},
      '{2'd0,1'b1,ST,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd2},
      '{2'd0,1'b1,LD,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd11},
      '{2'd0,1'b0,LD,1'b0,4'b0100,4'b0000,4'b0000,4'b0000,4'b0001,3'd3,4'd2},
      '{2'd0,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd2},
      '{2'd0,1'b0,LD,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd11},
      '{2'd0,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0011,3'd2,4'd2},
      '{2'd0,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd9},
      // processor: R3, R9
      '{2'd1,1'b1,ST,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd3},
      '{2'd1,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd3},
      '{2'd1,1'b1,LD,1'b0,4'b0010,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd3},
      '{2'd1,1'b0,LD,1'b0,4'b0100,4'b0000,4'b0000,4'b0000,4'b0010,3'd3,4'd3},
      '{2'd1,1'b1,FN,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0010,3'd2,4'd9},
      '{2'd1,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd7},
      '{2'd1,1'b0,LD,1'b0,4'b0100,4'b0000,4'b0000,4'b0000,4'b0000,3'd3,4'd3},
      '{2'd1,1'b0,LD,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,3'd3,4'd3},
      '{2'd1,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0111,3'd3,4'd3},
      '{2'd1,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd9},
      // processor, limbo behind store: R8
      '{2'd1,1'b1,ST,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd8},
      '{2'd1,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd8},
      '{2'd1,1'b0,LD,1'b0,4'b0010,4'b0010,4'b0000,4'b0000,4'b0000,3'd2,4'd8},
      '{2'd1,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0001,4'b0000,3'd2,4'd8},
      '{2'd1,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0010,3'd2,4'd8},
      '{2'd1,1'b0,LD,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd11},
      '{2'd1,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,3'd1,4'd3},
      '{2'd1,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd9},
      // release: R4, R5, R6, R7, R10
      '{2'd2,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd4},
      '{2'd2,1'b1,ST,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd4},
      '{2'd2,1'b1,LD,1'b0,4'b0010,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd4},
      '{2'd2,1'b0,LD,1'b0,4'b0100,4'b0100,4'b0000,4'b0000,4'b0010,3'd3,4'd4},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0010,4'b0000,4'b0000,3'd2,4'd5},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0010,3'd2,4'd5},
      '{2'd2,1'b1,FN,1'b1,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd6},
      '{2'd2,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd7},
      '{2'd2,1'b1,ST,1'b0,4'b0100,4'b0000,4'b0000,4'b0000,4'b0000,3'd3,4'd6},
      '{2'd2,1'b1,LD,1'b0,4'b1000,4'b0000,4'b0000,4'b0000,4'b0000,3'd4,4'd10},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b1000,3'd4,4'd6},
      '{2'd2,1'b0,LD,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,3'd3,4'd10},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0011,3'd3,4'd7},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,3'd1,4'd4},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd9},
      '{2'd2,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd6},
      '{2'd2,1'b1,FN,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,4'd6},
      '{2'd2,1'b1,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,4'd6},
      '{2'd2,1'b0,LD,1'b0,4'b0100,4'b0000,4'b0000,4'b0000,4'b0000,3'd3,4'd6},
      '{2'd2,1'b0,LD,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,4'b0100,3'd3,4'd6},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0011,3'd2,4'd7},
      '{2'd2,1'b0,LD,1'b0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,4'd9}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   model_sel = 2'd0;
   logic         enq_valid = 1'b0;
   logic [1:0]   enq_op = 2'd0;
   logic         enq_blk_ld = 1'b0;
   logic         enq_ready;
   logic [D-1:0] done_set = '0;
   logic [D-1:0] limbo_set = '0;
   logic [D-1:0] limbo_clr = '0;
   logic [D-1:0] addr_ok_set = '0;
   logic [D-1:0] retire_mask;
   logic [2:0]   occupancy;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   mrg_retire_gate #(.DEPTH(D)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .model_sel   (model_sel),
      .enq_valid   (enq_valid),
      .enq_op      (enq_op),
      .enq_blk_ld  (enq_blk_ld),
      .enq_ready   (enq_ready),
      .done_set    (done_set),
      .limbo_set   (limbo_set),
      .limbo_clr   (limbo_clr),
      .addr_ok_set (addr_ok_set),
      .retire_mask (retire_mask),
      .occupancy   (occupancy)
   );

   task automatic chk(input int req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      enq_valid   = 1'b0;
      enq_op      = LD;
      enq_blk_ld  = 1'b0;
      done_set    = '0;
      limbo_set   = '0;
      limbo_clr   = '0;
      addr_ok_set = '0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1: empty state after reset
      chk(1, "occupancy", int'(occupancy), 0);
      chk(1, "retire_mask", int'(retire_mask), 0);
      chk(1, "enq_ready", int'(enq_ready), 1);

      // table walk; R9 occupancy and R10 ready checked on every row
      for (int r = 0; r < 48; r++) begin
         @(negedge clk);
         model_sel   = TBL[r].md;
         enq_valid   = TBL[r].en;
         enq_op      = TBL[r].ty;
         enq_blk_ld  = TBL[r].bl;
         done_set    = TBL[r].pf;
         limbo_set   = TBL[r].ls;
         limbo_clr   = TBL[r].lc;
         addr_ok_set = TBL[r].rs;
         #2;
         chk(int'(TBL[r].rq), $sformatf("row %0d retire_mask", r), int'(retire_mask), int'(TBL[r].xrm));
         chk(9, $sformatf("row %0d occupancy", r), int'(occupancy), int'(TBL[r].xo));
         chk(10, $sformatf("row %0d enq_ready", r), int'(enq_ready), (TBL[r].xo < 3'd4) ? 1 : 0);
      end

      // directed: fill to full, dropped enqueue keeps count (R10)
      @(negedge clk);
      idle_inputs();
      model_sel = 2'd0;
      enq_valid = 1'b1;
      enq_op    = ST;
      for (int n = 0; n < 5; n++) @(negedge clk);
      #2;
      chk(10, "full occupancy", int'(occupancy), 4);
      chk(10, "full enq_ready", int'(enq_ready), 0);
      chk(2, "stores pending retire", int'(retire_mask), 0);

      // directed: reset from a full queue (R1)
      idle_inputs();
      rst_n = 1'b0;
      #2;
      chk(1, "async reset occupancy", int'(occupancy), 0);
      chk(1, "async reset retire_mask", int'(retire_mask), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(1, "post reset enq_ready", int'(enq_ready), 1);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule